// File: doc/BRIEF.md
# Timed Address-Event Readout Arbiter

This block collects contrast-change events from a pixel array of two lines with 256 pixels each. It turns them into a synchronous stream of timed address-events. Each pixel raises a level request together with a polarity bit. An increase in intensity is coded 1 and a decrease is coded 0. The pixel holds its request until it sees its acknowledge. The block copies the current value of a free-running time-stamp counter into that pixel's own register in the cycle the request is accepted. Queueing and arbitration delay therefore do not alter the time-stamp that is reported.

A time-stamp period is counted as closed once the counter has moved past it. Only closed periods are served, one at a time, oldest first. Within a period, events are granted in ascending address order. Each grant passes through three registered stages: grant, fetch and output. The output is a valid/ready stream of packets. Each packet holds the line, column, polarity and captured time-stamp. Pixels without a pending event take no part in arbitration, so output traffic tracks scene activity only.

Top module: `tae_readout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and every ev_ack bit is 0. The time-stamp counter restarts at 0.
- R2: The packet out_tae is 26 bits wide. Bit 25 is the line, bits 24:17 the column, bit 16 the polarity (1 = increase, 0 = decrease) and bits 15:0 the time-stamp. The pixel index is line*256 + column.
- R3: The reported time-stamp equals the counter value in the cycle the pixel's request was accepted. An idle pixel accepts a request that is high at a clock edge, and a tick at that same edge is not yet included. Waiting and back-pressure do not change it.
- R4: The counter advances by one at every clock edge where ts_tick is 1, and wraps modulo 2^16.
- R5: Events that carry the same time-stamp leave in ascending pixel index order, so all of line 0 leaves before line 1.
- R6: Every event of a period leaves before any event of a later period. A period is served only after at least one tick has closed it.
- R7: Each accepted request yields exactly one packet, and no packet appears without a request.
- R8: A pixel's ack rises one cycle after its grant, and out_valid rises two cycles after that when the pipeline is empty. At most one ack rises per cycle. Ack stays high until the pixel's request is low, and only then may that pixel start a new event.
- R9: With out_ready held high and several events waiting in a closed period, one packet leaves per clock with no gaps.
- R10: While out_valid is 1 and out_ready is 0, the next cycle still shows out_valid 1 with an unchanged out_tae. No packet is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_tick | input | 1 | One pulse per time-stamp period |
| ev_req | input | 512 | Per-pixel event request (level, held until ack) |
| ev_pol | input | 512 | Per-pixel polarity, valid with request |
| ev_ack | output | 512 | Per-pixel acknowledge |
| out_ready | input | 1 | Downstream can accept a packet |
| out_valid | output | 1 | Packet present on out_tae |
| out_tae | output | 26 | Timed address-event packet |

## Verification
Two things can fall on the same clock edge: a pixel can accept a new request while ts_tick advances the counter. The capture must then take the value from before the increment. The random phase pulses ts_tick at irregular intervals and raises requests on random pixels in the same cycles, so such collisions happen often. The bench's model records each expected time-stamp before it applies that edge's tick, and every packet's time-stamp field is compared against it. A second collision, a grant in the same cycle as an output stall, is provoked by a random out_ready and is judged by the hold and ordering checks.

// File: rtl/tae_pkg.sv
package tae_pkg;
    parameter int TAE_LINES = 2;
    parameter int TAE_COLS  = 256;
    parameter int TAE_TS_W  = 16;
    parameter bit TAE_POL_UP = 1'b1;
endpackage

// File: rtl/tae_pixel_bank.sv
module tae_pixel_bank #(
    parameter int NPIX  = 512,
    parameter int TS_W  = 16,
    parameter int IDX_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPIX-1:0]      ev_req,
    input  logic [NPIX-1:0]      ev_pol,
    input  logic [TS_W-1:0]      ts_now,
    input  logic [NPIX-1:0]      grant_vec,
    input  logic                 s1_valid,
    input  logic [IDX_W-1:0]     s1_idx,
    output logic [NPIX-1:0]      ev_ack,
    output logic [NPIX-1:0]      pend,
    output logic [NPIX*TS_W-1:0] cap_ts,
    output logic [NPIX-1:0]      cap_pol
);
    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        typedef struct packed {
            logic            pend;
            logic            ack;
            logic            pol;
            logic [TS_W-1:0] ts;
        } pix_t;

        pix_t px_d, px_q;
        logic in_fetch;

        always_comb begin
            px_d     = px_q;
            // keep ack (and so the stored stamp) while the grant stage still points here
            in_fetch = s1_valid && (s1_idx == IDX_W'(g));
            if (px_q.ack && !ev_req[g] && !in_fetch) begin
                px_d.ack = 1'b0;
            end
            if (!px_q.pend && !px_q.ack && ev_req[g]) begin
                px_d.pend = 1'b1;
                px_d.ts   = ts_now;
                px_d.pol  = ev_pol[g];
            end
            if (grant_vec[g]) begin
                px_d.pend = 1'b0;
                px_d.ack  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                px_q <= '0;
            end else begin
                px_q <= px_d;
            end
        end

        assign ev_ack[g]              = px_q.ack;
        assign pend[g]                = px_q.pend;
        assign cap_pol[g]             = px_q.pol;
        assign cap_ts[g*TS_W +: TS_W] = px_q.ts;
    end
endmodule

// File: rtl/tae_sched.sv
module tae_sched #(
    parameter int NPIX  = 512,
    parameter int TS_W  = 16,
    parameter int IDX_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ts_tick,
    input  logic [NPIX-1:0]      pend,
    input  logic [NPIX*TS_W-1:0] cap_ts,
    input  logic                 accept,
    output logic [TS_W-1:0]      ts_now,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_idx,
    output logic [NPIX-1:0]      grant_vec
);
    typedef struct packed {
        logic [TS_W-1:0] now;
        logic [TS_W-1:0] serve;
    } sched_t;

    sched_t           st_d, st_q;
    logic             closed;
    logic [NPIX-1:0]  batch;
    logic             found;
    logic [IDX_W-1:0] pick;

    always_comb begin
        // a period is eligible only once the counter has left it
        closed = (st_q.serve != st_q.now);
        for (int i = 0; i < NPIX; i++) begin
            batch[i] = pend[i] && closed && (cap_ts[i*TS_W +: TS_W] == st_q.serve);
        end
        found = 1'b0;
        pick  = '0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if (batch[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
        grant_valid = found && accept;
        grant_idx   = pick;
        grant_vec   = '0;
        if (grant_valid) begin
            grant_vec[pick] = 1'b1;
        end

        st_d = st_q;
        if (ts_tick) begin
            st_d.now = st_q.now + TS_W'(1);
        end
        if (!found && closed) begin
            st_d.serve = st_q.serve + TS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ts_now = st_q.now;
endmodule

// File: rtl/tae_pipe.sv
module tae_pipe #(
    parameter int NPIX  = 512,
    parameter int TS_W  = 16,
    parameter int IDX_W = 9,
    parameter int PKT_W = IDX_W + 1 + TS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant_valid,
    input  logic [IDX_W-1:0]     grant_idx,
    input  logic [NPIX*TS_W-1:0] cap_ts,
    input  logic [NPIX-1:0]      cap_pol,
    input  logic                 out_ready,
    output logic                 accept,
    output logic                 s1_valid,
    output logic [IDX_W-1:0]     s1_idx,
    output logic                 out_valid,
    output logic [PKT_W-1:0]     out_tae
);
    typedef struct packed {
        logic             v1;
        logic [IDX_W-1:0] idx1;
        logic             v2;
        logic [PKT_W-1:0] pkt2;
        logic             v3;
        logic [PKT_W-1:0] pkt3;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic  en1, en2, en3;

    always_comb begin
        en3 = !pp_q.v3 || out_ready;
        en2 = !pp_q.v2 || en3;
        en1 = !pp_q.v1 || en2;

        pp_d = pp_q;
        if (en3) begin
            pp_d.v3   = pp_q.v2;
            pp_d.pkt3 = pp_q.pkt2;
        end
        if (en2) begin
            pp_d.v2   = pp_q.v1;
            pp_d.pkt2 = {pp_q.idx1, cap_pol[pp_q.idx1],
                         cap_ts[int'(pp_q.idx1)*TS_W +: TS_W]};
        end
        if (en1) begin
            pp_d.v1   = grant_valid;
            pp_d.idx1 = grant_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign accept    = en1;
    assign s1_valid  = pp_q.v1;
    assign s1_idx    = pp_q.idx1;
    assign out_valid = pp_q.v3;
    assign out_tae   = pp_q.pkt3;
endmodule

// File: rtl/tae_readout.sv
module tae_readout
    import tae_pkg::*;
#(
    parameter  int LINES = TAE_LINES,
    parameter  int COLS  = TAE_COLS,
    parameter  int TS_W  = TAE_TS_W,
    localparam int NPIX  = LINES * COLS,
    localparam int IDX_W = $clog2(NPIX),
    localparam int PKT_W = IDX_W + 1 + TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_tick,
    input  logic [NPIX-1:0]  ev_req,
    input  logic [NPIX-1:0]  ev_pol,
    output logic [NPIX-1:0]  ev_ack,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [PKT_W-1:0] out_tae
);
    logic [NPIX-1:0]      pend;
    logic [NPIX*TS_W-1:0] cap_ts;
    logic [NPIX-1:0]      cap_pol;
    logic [TS_W-1:0]      ts_now;
    logic                 grant_valid;
    logic [IDX_W-1:0]     grant_idx;
    logic [NPIX-1:0]      grant_vec;
    logic                 accept;
    logic                 s1_valid;
    logic [IDX_W-1:0]     s1_idx;

    tae_pixel_bank #(.NPIX(NPIX), .TS_W(TS_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_req    (ev_req),
        .ev_pol    (ev_pol),
        .ts_now    (ts_now),
        .grant_vec (grant_vec),
        .s1_valid  (s1_valid),
        .s1_idx    (s1_idx),
        .ev_ack    (ev_ack),
        .pend      (pend),
        .cap_ts    (cap_ts),
        .cap_pol   (cap_pol)
    );

    tae_sched #(.NPIX(NPIX), .TS_W(TS_W), .IDX_W(IDX_W)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .ts_tick     (ts_tick),
        .pend        (pend),
        .cap_ts      (cap_ts),
        .accept      (accept),
        .ts_now      (ts_now),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_vec   (grant_vec)
    );

    tae_pipe #(.NPIX(NPIX), .TS_W(TS_W), .IDX_W(IDX_W), .PKT_W(PKT_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .cap_ts      (cap_ts),
        .cap_pol     (cap_pol),
        .out_ready   (out_ready),
        .accept      (accept),
        .s1_valid    (s1_valid),
        .s1_idx      (s1_idx),
        .out_valid   (out_valid),
        .out_tae     (out_tae)
    );
endmodule

// File: rtl/tae_readout_chk.sv
module tae_readout_chk #(
    parameter int NPIX  = 512,
    parameter int TS_W  = 16,
    parameter int IDX_W = 9,
    parameter int PKT_W = IDX_W + 1 + TS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ts_tick,
    input logic [NPIX-1:0]  ev_ack,
    input logic             out_ready,
    input logic             out_valid,
    input logic [PKT_W-1:0] out_tae
);
    localparam logic [TS_W-1:0] HALF = TS_W'(1) << (TS_W - 1);

    logic             have_last;
    logic [TS_W-1:0]  last_ts;
    logic [IDX_W-1:0] last_idx;
    logic [TS_W-1:0]  gap;
    logic [TS_W-1:0]  cur_ts;
    logic [IDX_W-1:0] cur_idx;
    logic [TS_W-1:0]  ts_delta;
    logic             xfer;
    logic             cmp_ok;

    assign cur_ts   = out_tae[TS_W-1:0];
    assign cur_idx  = out_tae[PKT_W-1 -: IDX_W];
    assign ts_delta = cur_ts - last_ts;
    assign xfer     = out_valid && out_ready;
    assign cmp_ok   = have_last && (gap < HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_ts   <= '0;
            last_idx  <= '0;
            gap       <= '0;
        end else if (xfer) begin
            have_last <= 1'b1;
            last_ts   <= cur_ts;
            last_idx  <= cur_idx;
            gap       <= ts_tick ? TS_W'(1) : '0;
        end else if (ts_tick && gap < HALF) begin
            gap <= gap + TS_W'(1);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && ev_ack == '0));

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tae)));

    a_r8_one_new_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_ack & ~$past(ev_ack)));

    a_r6_ts_order: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cmp_ok) |-> (ts_delta < HALF));

    a_r5_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cmp_ok && ts_delta == '0) |-> (cur_idx > last_idx));
endmodule

bind tae_readout tae_readout_chk #(
    .NPIX(NPIX), .TS_W(TS_W), .IDX_W(IDX_W), .PKT_W(PKT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts_tick   (ts_tick),
    .ev_ack    (ev_ack),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_tae   (out_tae)
);

// File: tb/tae_readout_bench.sv
module tae_readout_bench;
    localparam int NPIX  = 512;
    localparam int TS_W  = 16;
    localparam int IDX_W = 9;
    localparam int PKT_W = IDX_W + 1 + TS_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ts_tick = 1'b0;
    logic [NPIX-1:0]  ev_req = '0;
    logic [NPIX-1:0]  ev_pol = '0;
    logic [NPIX-1:0]  ev_ack;
    logic             out_ready = 1'b0;
    logic             out_valid;
    logic [PKT_W-1:0] out_tae;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ts_model = 0;
    int n_ev = 0;
    int n_pkt = 0;
    bit m_out [NPIX];
    int m_ts  [NPIX];
    bit m_pol [NPIX];
    bit m_ackd[NPIX];

    tae_readout u_tae_readout (
        .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick),
        .ev_req(ev_req), .ev_pol(ev_pol), .ev_ack(ev_ack),
        .out_ready(out_ready), .out_valid(out_valid), .out_tae(out_tae)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int oldest();
        int best = -1;
        for (int i = 0; i < NPIX; i++) begin
            if (m_out[i] && (best < 0 || m_ts[i] < m_ts[best])) best = i;
        end
        return best;
    endfunction

    function automatic int outstanding();
        int n = 0;
        for (int i = 0; i < NPIX; i++) n += int'(m_out[i]);
        return n;
    endfunction

    task automatic score(input logic [PKT_W-1:0] pkt);
        int idx = int'(pkt[PKT_W-1 -: IDX_W]);
        int ts  = int'(pkt[TS_W-1:0]);
        int exp = oldest();
        n_pkt++;
        if (exp < 0) begin
            chk(1'b0, "R7 spurious packet", idx, -1);
        end else begin
            chk(idx == exp, "R5/R6 order", idx, exp);
            chk(ts == (m_ts[exp] & 32'hFFFF), "R3/R4 stamp", ts, m_ts[exp] & 32'hFFFF);
            chk(pkt[TS_W] == m_pol[exp], "R2 polarity", int'(pkt[TS_W]), int'(m_pol[exp]));
            chk(m_ackd[exp], "R8 ack before packet", int'(m_ackd[exp]), 1);
            m_out[exp] = 1'b0;
        end
    endtask

    // one clock: sample the values present at the coming edge, then move to the next low phase
    task automatic step();
        logic             pv = out_valid;
        logic             pr = out_ready;
        logic             pt = ts_tick;
        logic [PKT_W-1:0] pk = out_tae;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (rst_n) ts_model += int'(pt);
        if (pv && pr) score(pk);
        if (pv && !pr) begin
            chk(out_valid && out_tae == pk, "R10 held packet", int'(out_tae), int'(pk));
        end
        for (int i = 0; i < NPIX; i++) begin
            if (ev_ack[i]) begin
                m_ackd[i] = 1'b1;
                if (ev_req[i]) ev_req[i] = 1'b0;
            end
        end
    endtask

    task automatic raise(input int i, input bit pol);
        if (!ev_req[i] && !ev_ack[i] && !m_out[i]) begin
            ev_req[i] = 1'b1;
            ev_pol[i] = pol;
            m_out[i]  = 1'b1;
            m_ts[i]   = ts_model;
            m_pol[i]  = pol;
            m_ackd[i] = 1'b0;
            n_ev++;
        end
    endtask

    task automatic drain(input int lim);
        out_ready = 1'b1;
        for (int k = 0; k < lim; k++) begin
            ts_tick = (k % 3 == 0);
            step();
            if (outstanding() == 0 && !out_valid && ev_ack == '0) break;
        end
        ts_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7 watchdog", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t_ack, t_val, first, run;
        int burst [8] = '{5, 17, 255, 256, 400, 511, 0, 100};
        void'($urandom(32'd20250611));

        // R1: quiet during reset
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(ev_ack == '0, "R1 ack in reset", int'($countones(ev_ack)), 0);
        rst_n = 1'b1;
        step();
        chk(out_valid == 1'b0 && ev_ack == '0, "R1 first cycle", int'(out_valid), 0);

        // R7: no requests, no packets
        run = 0;
        out_ready = 1'b1;
        for (int k = 0; k < 40; k++) begin
            ts_tick = (k % 2 == 0);
            step();
            run += int'(out_valid);
        end
        chk(run == 0, "R7 idle output", run, 0);

        // R8: ack to output latency on an empty pipeline
        ts_tick = 1'b0;
        raise(300, 1'b1);
        t_ack = -1;
        t_val = -1;
        for (int k = 0; k < 40; k++) begin
            ts_tick = (k == 1);
            step();
            if (ev_ack[300] && t_ack < 0) t_ack = cyc;
            if (out_valid && t_val < 0) t_val = cyc;
        end
        ts_tick = 1'b0;
        chk(t_ack >= 0 && t_val - t_ack == 2, "R8 ack to valid", t_val - t_ack, 2);

        // R9 and R5: a full batch in one period, across the line boundary
        foreach (burst[j]) raise(burst[j], j[0]);
        first = -1;
        run = 0;
        for (int k = 0; k < 40; k++) begin
            ts_tick = (k == 1);
            step();
            if (out_valid && first < 0) first = cyc;
            if (first >= 0 && cyc < first + 8 && out_valid) run++;
        end
        ts_tick = 1'b0;
        chk(run == 8, "R9 back-to-back burst", run, 8);

        // R6: high address in an earlier period must precede low address in a later one
        raise(450, 1'b0);
        ts_tick = 1'b1;
        step();
        ts_tick = 1'b0;
        raise(3, 1'b1);
        ts_tick = 1'b1;
        step();
        drain(200);

        // random traffic with back-pressure and ticks colliding with captures (R3, R10)
        for (int k = 0; k < 6000; k++) begin
            for (int j = 0; j < 3; j++) begin
                if ($urandom % 4 == 0) raise(int'($urandom % NPIX), 1'($urandom % 2));
            end
            ts_tick   = ($urandom % 5 == 0);
            out_ready = ($urandom % 10 < 7);
            step();
        end
        drain(3000);
        chk(outstanding() == 0, "R7 all delivered", outstanding(), 0);
        chk(n_pkt == n_ev, "R7 one packet per event", n_pkt, n_ev);

        // R4: counter wrap after 2^16 + 3 ticks
        out_ready = 1'b1;
        ts_tick   = 1'b1;
        for (int k = 0; k < 65539; k++) step();
        ts_tick = 1'b0;
        chk((ts_model & 32'hFFFF) == ((ts_model - 65536) & 32'hFFFF), "R4 model wrap", ts_model, ts_model);
        raise(7, 1'b1);
        step();
        drain(200);
        chk(n_pkt == n_ev, "R4 wrapped event out", n_pkt, n_ev);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule